// File: doc/BRIEF.md
# SDRAM Start-Up Sequencer

This block drives the command, address, bank, clock-enable and byte-mask pins of an SDRAM from reset until the memory is ready for normal traffic. It first holds the bus idle for a long settling pause with clock-enable and all byte masks high. It then closes every bank with a single precharge, runs a parameterised number of auto-refresh commands at a fixed spacing, and programs the mode register from build-time parameters (burst length, burst ordering, CAS latency). One idle cycle follows, and then the done flag rises.

Once the done flag is high, the block becomes a plain pass-through: the pins follow the normal command scheduler's inputs in the same cycle. Before that point, anything the scheduler drives is dropped. All delays are counted in clock cycles and set by parameters. The default pause of 26667 cycles is 200 us at 133 MHz.

The controller is one state machine with these states:
- ST_PAUSE: settling wait.
- ST_PRECHARGE: one cycle.
- ST_WAIT_RP: precharge-to-refresh wait.
- ST_REFRESH: one cycle.
- ST_WAIT_RC: refresh recovery.
- ST_LOAD_MODE: one cycle.
- ST_TAIL_NOP: one cycle.
- ST_DONE: terminal.

The transitions are:
- PAUSE to PRECHARGE when the pause timer expires.
- PRECHARGE to WAIT_RP unconditionally.
- WAIT_RP to REFRESH when the timer expires.
- REFRESH to WAIT_RC unconditionally.
- WAIT_RC back to REFRESH on expiry while refreshes remain, or to LOAD_MODE on expiry once all are issued.
- LOAD_MODE to TAIL_NOP, then TAIL_NOP to DONE.
- Any state goes back to PAUSE when reset is asserted.

Top module: `sdram_boot_seq`

## Requirements
- R1: While rst_n is low, the block drives a NOP (cs,ras,cas,we = 0,1,1,1), address 0, bank 0, CKE high, every DQM bit high, and init_done low.
- R2: After reset is released, number the rising edges with rst_n high from 1. After edges 1 to PAUSE_CYC-1, the pins show a NOP with address and bank 0, CKE high and all DQM bits high.
- R3: After edge PAUSE_CYC, for exactly one cycle, the pins show precharge-all (cs,ras,cas,we = 0,0,1,0). Address bit 10 is 1, all other address bits are 0, and the bank is 0.
- R4: Exactly REFRESH_N auto-refresh commands (0,0,0,1) are issued, with address and bank 0. The first comes TRP_CYC cycles after the precharge, and each later one comes TRC_CYC cycles after the one before. Every cycle between them is a NOP.
- R5: The mode load command (0,0,0,0) comes TRC_CYC cycles after the last refresh, with bank 0.
- R6: During the mode load, the address carries the mode word, and all other address bits are 0:
  - A2..A0 is the burst code: BURST_LEN 1 gives 0, 2 gives 1, 4 gives 2, 8 gives 3, and 0 (full page) gives 7.
  - A3 is BURST_INTERLEAVE (1 selects interleaved order).
  - A6..A4 is CAS_LAT (2 or 3).
- R7: Exactly one NOP follows the mode load. init_done rises in the next cycle and stays high until reset.
- R8: While init_done is low, the scheduler inputs have no effect on any output, and CKE and all DQM bits stay high.
- R9: While init_done is high, each output pin equals its scheduler input in the same cycle.
- R10: Asserting reset at any point in the sequence returns the outputs to the R1 state at once. After the next release, the whole sequence restarts from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_cs_n | input | 1 | Scheduler chip select |
| sched_ras_n | input | 1 | Scheduler row strobe |
| sched_cas_n | input | 1 | Scheduler column strobe |
| sched_we_n | input | 1 | Scheduler write enable |
| sched_addr | input | ROW_W | Scheduler address |
| sched_bank | input | BANK_W | Scheduler bank address |
| sched_cke | input | 1 | Scheduler clock enable |
| sched_dqm | input | DQM_W | Scheduler byte masks |
| sdr_cs_n | output | 1 | Memory chip select |
| sdr_ras_n | output | 1 | Memory row strobe |
| sdr_cas_n | output | 1 | Memory column strobe |
| sdr_we_n | output | 1 | Memory write enable |
| sdr_addr | output | ROW_W | Memory address bus |
| sdr_bank | output | BANK_W | Memory bank address |
| sdr_cke | output | 1 | Memory clock enable |
| sdr_dqm | output | DQM_W | Memory byte masks |
| init_done | output | 1 | High once start-up has completed |

## Verification
A state register or timer that is off by one moves a command to a different cycle. The bench sees this at the pins on the very cycle the precharge, a refresh or the mode load was expected, because it compares every cycle against a schedule it computes itself.

A refresh counter that ends early or late changes how many refresh codes appear before the mode load, and the first misplaced command exposes it. A wrong handover condition shows up immediately: either scheduler noise leaks through during start-up, or the pins fail to track the scheduler in the first cycle after init_done.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Command code packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE    = 4'b0000,
        CMD_REFRESH = 4'b0001,
        CMD_PRECHG  = 4'b0010,
        CMD_NOP     = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_LOAD_MODE,
        ST_TAIL_NOP,
        ST_DONE
    } boot_state_e;

    // Burst length to mode field code; a length of 0 means full page
    function automatic logic [2:0] burst_code(input int len);
        case (len)
            1:       return 3'd0;
            2:       return 3'd1;
            4:       return 3'd2;
            8:       return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int W         = 16,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Down-counter that stops at zero; reloaded by the controller
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RESET_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/boot_refresh_ctr.sv
module boot_refresh_ctr #(
    parameter int TOTAL = 8,
    localparam int W    = $clog2(TOTAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic all_issued
);
    logic [W-1:0] issued;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            issued <= '0;
        else if (step && issued != W'(TOTAL))
            issued <= issued + 1'b1;
    end

    assign all_issued = (issued == W'(TOTAL));
endmodule

// File: rtl/boot_mode_word.sv
module boot_mode_word #(
    parameter int ROW_W            = 13,
    parameter int BURST_LEN        = 4,
    parameter int BURST_INTERLEAVE = 0,
    parameter int CAS_LAT          = 3
) (
    output logic [ROW_W-1:0] mode_word,
    output logic [ROW_W-1:0] prechg_word
);
    import sdram_boot_pkg::*;

    localparam logic [2:0] BL_CODE = burst_code(BURST_LEN);
    localparam logic       IL_BIT  = (BURST_INTERLEAVE != 0);
    localparam logic [2:0] CL_CODE = 3'(CAS_LAT);
    localparam int         AP_BIT  = 10;

    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = BL_CODE;
        mode_word[3]   = IL_BIT;
        mode_word[6:4] = CL_CODE;
    end

    always_comb begin
        prechg_word         = '0;
        prechg_word[AP_BIT] = 1'b1;
    end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq #(
    parameter int ROW_W            = 13,
    parameter int BANK_W           = 2,
    parameter int DQM_W            = 2,
    parameter int PAUSE_CYC        = 26667,
    parameter int TRP_CYC          = 3,
    parameter int TRC_CYC          = 10,
    parameter int REFRESH_N        = 8,
    parameter int BURST_LEN        = 4,
    parameter int BURST_INTERLEAVE = 0,
    parameter int CAS_LAT          = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sched_cs_n,
    input  logic              sched_ras_n,
    input  logic              sched_cas_n,
    input  logic              sched_we_n,
    input  logic [ROW_W-1:0]  sched_addr,
    input  logic [BANK_W-1:0] sched_bank,
    input  logic              sched_cke,
    input  logic [DQM_W-1:0]  sched_dqm,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic [ROW_W-1:0]  sdr_addr,
    output logic [BANK_W-1:0] sdr_bank,
    output logic              sdr_cke,
    output logic [DQM_W-1:0]  sdr_dqm,
    output logic              init_done
);
    import sdram_boot_pkg::*;

    localparam int MAX_A  = (PAUSE_CYC > TRP_CYC) ? PAUSE_CYC : TRP_CYC;
    localparam int MAX_C  = (MAX_A > TRC_CYC) ? MAX_A : TRC_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    boot_state_e      state, state_nxt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             ref_step;
    logic             ref_all;
    logic [ROW_W-1:0] mode_word, prechg_word;
    sdr_cmd_e         seq_cmd;
    logic [ROW_W-1:0] seq_addr;

    boot_timer #(.W(CNT_W), .RESET_VAL(PAUSE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    boot_refresh_ctr #(.TOTAL(REFRESH_N)) u_refcnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (ref_step),
        .all_issued (ref_all)
    );

    boot_mode_word #(
        .ROW_W            (ROW_W),
        .BURST_LEN        (BURST_LEN),
        .BURST_INTERLEAVE (BURST_INTERLEAVE),
        .CAS_LAT          (CAS_LAT)
    ) u_mode (
        .mode_word   (mode_word),
        .prechg_word (prechg_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_PAUSE;
        else
            state <= state_nxt;
    end

    // Next state, timer reload and refresh count
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ref_step  = 1'b0;
        unique case (state)
            ST_PAUSE:     if (tmr_expired) state_nxt = ST_PRECHARGE;
            ST_PRECHARGE: begin
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(TRP_CYC - 2);
                state_nxt = ST_WAIT_RP;
            end
            ST_WAIT_RP:   if (tmr_expired) state_nxt = ST_REFRESH;
            ST_REFRESH: begin
                tmr_load  = 1'b1;
                tmr_val   = CNT_W'(TRC_CYC - 2);
                ref_step  = 1'b1;
                state_nxt = ST_WAIT_RC;
            end
            ST_WAIT_RC:
                if (tmr_expired) state_nxt = ref_all ? ST_LOAD_MODE : ST_REFRESH;
            ST_LOAD_MODE: state_nxt = ST_TAIL_NOP;
            ST_TAIL_NOP:  state_nxt = ST_DONE;
            ST_DONE:      state_nxt = ST_DONE;
            default:      state_nxt = ST_PAUSE;
        endcase
    end

    // Sequence outputs per state
    always_comb begin
        seq_cmd  = CMD_NOP;
        seq_addr = '0;
        unique case (state)
            ST_PRECHARGE: begin
                seq_cmd  = CMD_PRECHG;
                seq_addr = prechg_word;
            end
            ST_REFRESH:   seq_cmd = CMD_REFRESH;
            ST_LOAD_MODE: begin
                seq_cmd  = CMD_MODE;
                seq_addr = mode_word;
            end
            default: begin
                seq_cmd  = CMD_NOP;
                seq_addr = '0;
            end
        endcase
    end

    assign init_done = (state == ST_DONE);

    // Handover to the scheduler once start-up is complete
    always_comb begin
        if (init_done) begin
            {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} =
                {sched_cs_n, sched_ras_n, sched_cas_n, sched_we_n};
            sdr_addr = sched_addr;
            sdr_bank = sched_bank;
            sdr_cke  = sched_cke;
            sdr_dqm  = sched_dqm;
        end else begin
            {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = seq_cmd;
            sdr_addr = seq_addr;
            sdr_bank = '0;
            sdr_cke  = 1'b1;
            sdr_dqm  = '1;
        end
    end
endmodule

// File: rtl/sdram_boot_seq_chk.sv
module sdram_boot_seq_chk #(
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2,
    parameter int DQM_W     = 2,
    parameter int REFRESH_N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ROW_W-1:0]  addr,
    input logic [BANK_W-1:0] bank,
    input logic              cke,
    input logic [DQM_W-1:0]  dqm,
    input logic              done
);
    localparam int RW = $clog2(REFRESH_N + 2);

    logic [3:0]    cmd;
    logic          is_mode, is_ref, is_pre, is_nop;
    logic [RW-1:0] refs_seen;

    assign cmd     = {cs_n, ras_n, cas_n, we_n};
    assign is_mode = !done && cmd == 4'b0000;
    assign is_ref  = !done && cmd == 4'b0001;
    assign is_pre  = !done && cmd == 4'b0010;
    assign is_nop  = cmd == 4'b0111;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            refs_seen <= '0;
        else if (is_ref && refs_seen != {RW{1'b1}})
            refs_seen <= refs_seen + 1'b1;
    end

    a_r8_pins_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (cke && &dqm));

    a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[10]);

    a_r4_refresh_count: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> refs_seen == RW'(REFRESH_N));

    a_r5_mode_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> bank == '0);

    a_r7_nop_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |=> (is_nop && !done));

    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |=> ##1 done);

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
    .ROW_W     (ROW_W),
    .BANK_W    (BANK_W),
    .DQM_W     (DQM_W),
    .REFRESH_N (REFRESH_N)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (sdr_cs_n),
    .ras_n (sdr_ras_n),
    .cas_n (sdr_cas_n),
    .we_n  (sdr_we_n),
    .addr  (sdr_addr),
    .bank  (sdr_bank),
    .cke   (sdr_cke),
    .dqm   (sdr_dqm),
    .done  (init_done)
);

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;
    localparam int ROW_W = 13, BANK_W = 2, DQM_W = 2;
    localparam int P = 40, TRP = 3, TRC = 6, NREF = 8;
    localparam int BL = 8, IL = 1, CL = 2;
    localparam int T_REF0 = P + TRP;
    localparam int T_MODE = T_REF0 + NREF * TRC;
    localparam int T_DONE = T_MODE + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_cs, s_ras, s_cas, s_we, s_cke;
    logic [ROW_W-1:0] s_addr;
    logic [BANK_W-1:0] s_bank;
    logic [DQM_W-1:0] s_dqm;
    logic o_cs, o_ras, o_cas, o_we, o_cke, done;
    logic [ROW_W-1:0] o_addr;
    logic [BANK_W-1:0] o_bank;
    logic [DQM_W-1:0] o_dqm;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sdram_boot_seq #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .DQM_W(DQM_W), .PAUSE_CYC(P),
        .TRP_CYC(TRP), .TRC_CYC(TRC), .REFRESH_N(NREF), .BURST_LEN(BL),
        .BURST_INTERLEAVE(IL), .CAS_LAT(CL)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .sched_cs_n(s_cs), .sched_ras_n(s_ras), .sched_cas_n(s_cas),
        .sched_we_n(s_we), .sched_addr(s_addr), .sched_bank(s_bank),
        .sched_cke(s_cke), .sched_dqm(s_dqm),
        .sdr_cs_n(o_cs), .sdr_ras_n(o_ras), .sdr_cas_n(o_cas), .sdr_we_n(o_we),
        .sdr_addr(o_addr), .sdr_bank(o_bank), .sdr_cke(o_cke), .sdr_dqm(o_dqm),
        .init_done(done)
    );

    // R6 mode word from the requirement's field layout
    function automatic logic [ROW_W-1:0] mode_word();
        logic [2:0] blc;
        case (BL)
            1: blc = 3'd0; 2: blc = 3'd1; 4: blc = 3'd2; 8: blc = 3'd3;
            default: blc = 3'd7;
        endcase
        return ROW_W'(blc) | (ROW_W'(IL) << 3) | (ROW_W'(CL) << 4);
    endfunction

    function automatic logic [3:0] exp_cmd(int t);
        if (t == P) return 4'b0010;
        if (t >= T_REF0 && t < T_MODE && ((t - T_REF0) % TRC) == 0) return 4'b0001;
        if (t == T_MODE) return 4'b0000;
        return 4'b0111;
    endfunction

    function automatic logic [ROW_W-1:0] exp_addr(int t);
        if (t == P) return ROW_W'(1) << 10;
        if (t == T_MODE) return mode_word();
        return '0;
    endfunction

    function automatic string tag_of(int t);
        if (t < P) return "R2 R8";
        if (t == P) return "R3";
        if (t < T_MODE) return "R4";
        if (t == T_MODE) return "R5 R6";
        return "R7";
    endfunction

    function automatic logic [31:0] pins();
        return {o_cs, o_ras, o_cas, o_we, o_addr, o_bank, o_cke, o_dqm, done};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_sched(input bit zeros);
        if (zeros) begin
            {s_cs, s_ras, s_cas, s_we, s_cke} = '0;
            s_addr = '0; s_bank = '0; s_dqm = '0;
        end else begin
            {s_cs, s_ras, s_cas, s_we, s_cke} = 5'($urandom);
            s_addr = ROW_W'($urandom); s_bank = BANK_W'($urandom);
            s_dqm = DQM_W'($urandom);
        end
    endtask

    function automatic logic [31:0] idle_pins();
        return {4'b0111, ROW_W'(0), BANK_W'(0), 1'b1, {DQM_W{1'b1}}, 1'b0};
    endfunction

    // Runs from reset release; stop_at > 0 asserts reset after that sample
    task automatic run_boot(input int stop_at, input bit zeros);
        rst_n = 1'b1;
        for (int t = 1; t <= T_DONE + 20; t++) begin
            @(negedge clk);
            if (t < T_DONE)
                check(tag_of(t), pins(),
                      {exp_cmd(t), exp_addr(t), BANK_W'(0), 1'b1, {DQM_W{1'b1}}, 1'b0});
            else
                check("R9 R7", pins(),
                      {s_cs, s_ras, s_cas, s_we, s_addr, s_bank, s_cke, s_dqm, 1'b1});
            if (t == stop_at) begin
                rst_n = 1'b0;
                #1;
                check("R10", pins(), idle_pins());
                return;
            end
            #1 drive_sched(zeros);
        end
    endtask

    initial begin
        void'($urandom(32'h1d2c3b4a));
        drive_sched(1'b0);
        repeat (3) @(negedge clk);
        check("R1", pins(), idle_pins());
        check("R6 word", 32'(mode_word()), 32'h2B);
        run_boot(0, 1'b0);
        // Mid-sequence reset during the refresh phase
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1 R10", pins(), idle_pins());
        @(negedge clk);
        run_boot(T_REF0 + 2 * TRC, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 held", pins(), idle_pins());
        // Directed: scheduler drives all-zero (mode-load look-alike) during start-up
        drive_sched(1'b1);
        run_boot(0, 1'b1);
        // Reset straight after the mode load cycle
        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1", pins(), idle_pins());
        @(negedge clk);
        run_boot(T_MODE + 1, 1'b0);
        @(negedge clk);
        run_boot(0, 1'b0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule